// File: doc/BRIEF.md
# True/Complement Zero/One Word Conditioner

This block conditions a data word before it is loaded into a register of an add/subtract datapath, or before it is used as a preload value for a counter. Two control lines choose one of four functions for the whole word. The functions are the bitwise inverse of the input, a word of all ones, the input passed through unchanged, and a word of all zeros.

The element is purely combinational. It has no clock, no reset and no storage, so the output follows any change on the data or control inputs within the same cycle. The word width is a parameter with a default of 4 bits, and the chosen function applies identically to every bit at any width. The complement is a plain ones' complement of a straight binary word.

The two control lines together form a two-bit code, written here as {true_sel, force_en}.

Top module: `word_cond_elem`

## Requirements
- R1: With true_sel=0 and force_en=0 (code 2'b00), every bit of dout is the inverse of the same bit of din, so that dout = (2^WIDTH - 1) - din.
- R2: With true_sel=0 and force_en=1 (code 2'b01), every bit of dout is 1, so that dout = 2^WIDTH - 1.
- R3: With true_sel=1 and force_en=0 (code 2'b10), dout equals din.
- R4: With true_sel=1 and force_en=1 (code 2'b11), every bit of dout is 0.
- R5: WIDTH is a parameter with a default of 4, and R1 to R4 hold for every bit at any width, including a width of 1 and widths other than 4.
- R6: The block is combinational. dout reflects a change on din or on the controls without any clock edge.
- R7: While force_en=1, din has no effect on dout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Data word to be conditioned |
| true_sel | input | 1 | High code bit: 1 selects the true value or zeros, 0 selects the complement or ones |
| force_en | input | 1 | Low code bit: 1 forces a constant word, 0 passes data (true or inverted) |
| dout | output | WIDTH | Conditioned word |

## Verification
The only internal state is the decoded one-hot function select. If that select were wrong, the wrong function would appear on dout in the same cycle as the control change. Some examples: a pass that comes out inverted, a forced word that still follows din, or a single bit slice that lags the others. The bench computes every expected word arithmetically, for every code and every input word, at three widths. Any wrong bit is therefore visible as soon as the inputs settle.

// File: rtl/word_cond_pkg.sv
package word_cond_pkg;

  localparam int unsigned CODE_W = 2;
  localparam int unsigned N_FUNC = 1 << CODE_W;

  // code = {true_sel, force_en}
  typedef enum logic [CODE_W-1:0] {
    FN_INVERT = 2'b00,
    FN_ONES   = 2'b01,
    FN_PASS   = 2'b10,
    FN_ZEROS  = 2'b11
  } cond_fn_e;

  typedef logic [N_FUNC-1:0] fn_onehot_t;

  // One bit of conditioning, driven by the one-hot select.
  // The zeros function asserts none of the terms.
  function automatic logic cond_bit(input fn_onehot_t sel, input logic x);
    return (sel[FN_INVERT] & ~x) | sel[FN_ONES] | (sel[FN_PASS] & x);
  endfunction

endpackage

// File: rtl/wc_decode.sv
module wc_decode
  import word_cond_pkg::*;
(
  input  logic       true_sel,
  input  logic       force_en,
  output fn_onehot_t sel_oh
);

  cond_fn_e fn_code;

  assign fn_code = cond_fn_e'({true_sel, force_en});

  always_comb begin
    sel_oh = '0;
    sel_oh[fn_code] = 1'b1;
  end

  always_comb begin
    if (!$isunknown({true_sel, force_en})) begin
      AST_SEL_ONEHOT: assert ($countones(sel_oh) == 1); // R6
      AST_FORCE_NO_DATA: assert (!force_en || (sel_oh[FN_INVERT] == 1'b0 && sel_oh[FN_PASS] == 1'b0)); // R7
    end
  end

endmodule

// File: rtl/wc_slice.sv
module wc_slice
  import word_cond_pkg::*;
(
  input  fn_onehot_t sel_oh,
  input  logic       din_bit,
  output logic       dout_bit
);

  assign dout_bit = cond_bit(sel_oh, din_bit);

endmodule

// File: rtl/word_cond_elem.sv
module word_cond_elem
  import word_cond_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] din,
  input  logic             true_sel,
  input  logic             force_en,
  output logic [WIDTH-1:0] dout
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  fn_onehot_t sel_oh;

  wc_decode u_decode (
    .true_sel (true_sel),
    .force_en (force_en),
    .sel_oh   (sel_oh)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    wc_slice u_slice (
      .sel_oh   (sel_oh),
      .din_bit  (din[i]),
      .dout_bit (dout[i])
    );
  end

  always_comb begin
    if (!$isunknown({din, true_sel, force_en})) begin
      AST_INVERT_WORD: assert (!(!true_sel && !force_en) || ((dout ^ din) == ALL_ONES)); // R1
      AST_ONES_WORD: assert (!(!true_sel && force_en) || (dout == ALL_ONES)); // R2
      AST_PASS_WORD: assert (!(true_sel && !force_en) || (dout == din)); // R3
      AST_ZERO_WORD: assert (!(true_sel && force_en) || (dout == '0)); // R4
    end
  end

endmodule

// File: tb/tb_word_cond_elem.sv
`timescale 1ns/1ps
module tb_word_cond_elem;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [3:0] d4;   logic ts4, fe4;  logic [3:0] q4;
  logic [0:0] d1;   logic ts1, fe1;  logic [0:0] q1;
  logic [6:0] d7;   logic ts7, fe7;  logic [6:0] q7;

  word_cond_elem dut (.din(d4), .true_sel(ts4), .force_en(fe4), .dout(q4));
  word_cond_elem #(.WIDTH(1)) dut_w1 (.din(d1), .true_sel(ts1), .force_en(fe1), .dout(q1));
  word_cond_elem #(.WIDTH(7)) dut_w7 (.din(d7), .true_sel(ts7), .force_en(fe7), .dout(q7));

  // Expected word computed arithmetically from the code.
  function automatic int expect_word(int code, int x, int n);
    int top = (1 << n) - 1;
    case (code)
      0: return top - x;   // R1 complement
      1: return top;       // R2 ones
      2: return x;         // R3 pass
      default: return 0;   // R4 zeros
    endcase
  endfunction

  function automatic string req_of(int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
    end
  endtask

  initial begin
    d4 = '0; ts4 = 1'b0; fe4 = 1'b0;
    d1 = '0; ts1 = 1'b0; fe1 = 1'b0;
    d7 = '0; ts7 = 1'b0; fe7 = 1'b0;
    @(negedge clk);
    // Initial condition: code 00 with din 0 gives all ones
    check("R1", int'(q4), 15);

    // Full sweep at the default width
    for (int code = 0; code < 4; code++) begin
      for (int x = 0; x < 16; x++) begin
        @(posedge clk);
        {ts4, fe4} = 2'(code);
        d4 = 4'(x);
        @(negedge clk);
        check(req_of(code), int'(q4), expect_word(code, x, 4));
      end
    end

    // R5: width 1 and width 7
    for (int code = 0; code < 4; code++) begin
      for (int x = 0; x < 2; x++) begin
        @(posedge clk);
        {ts1, fe1} = 2'(code); d1 = 1'(x);
        @(negedge clk);
        check("R5", int'(q1), expect_word(code, x, 1));
      end
      for (int x = 0; x < 128; x++) begin
        @(posedge clk);
        {ts7, fe7} = 2'(code); d7 = 7'(x);
        @(negedge clk);
        check("R5", int'(q7), expect_word(code, x, 7));
      end
    end

    // R7: with force_en high, din toggles but dout holds
    for (int ts = 0; ts < 2; ts++) begin
      @(posedge clk);
      ts4 = 1'(ts); fe4 = 1'b1; d4 = 4'h0;
      @(negedge clk);
      for (int x = 1; x < 16; x++) begin
        #0.5 d4 = 4'(x);
        #0.2 check("R7", int'(q4), (ts == 0) ? 15 : 0);
      end
    end

    // R6: changes between clock edges show up at once
    @(posedge clk);
    ts4 = 1'b1; fe4 = 1'b0; d4 = 4'h5;
    #0.6 check("R6", int'(q4), 5);
    d4 = 4'hA;
    #0.3 check("R6", int'(q4), 10);
    ts4 = 1'b0;
    #0.3 check("R6", int'(q4), 5);
    fe4 = 1'b1;
    #0.3 check("R6", int'(q4), 15);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule